// File: doc/BRIEF.md
# Command Word Illegalization Lookup

This block decides, for each decoded remote-terminal command, whether the command is to be refused as illegal. The host marks forbidden message types in a bitmap of 256 sixteen-bit words held in a RAM region at word addresses 0x300 through 0x3FF. Each bit stands for one combination of addressing kind (broadcast or own address), direction, subaddress and five-bit word count or mode code. That makes 4096 combinations, and any one of them can be forbidden without affecting the rest.

A lookup starts with a one-cycle strobe carrying the decoded command fields. The block turns the fields into one table word address and reads that word through the single RAM port. It then picks one bit of the returned word and, one cycle later, presents a verdict with a one-cycle done pulse. It also reports whether the five-bit field was read as a mode code, which is the case at subaddresses 0 and 31. A simple write port lets the host fill the table. That port shares the RAM port with lookups, and a lookup wins any cycle in which both ask for it.

Top module: `cmd_illegal_lookup`

## Requirements
- R1: The table word read for a lookup is 0x300 + {own, tx, sa[4:0], code[4]}. Here own=1 means own address and 0 means broadcast, and tx=1 means transmit and 0 means receive. So broadcast receive starts at 0x300, broadcast transmit at 0x340, own receive at 0x380 and own transmit at 0x3C0.
- R2: The verdict is bit code[3:0] of the selected word, where 1 means illegal and 0 means legal. The lower word of a subaddress pair covers codes 0–15 and the upper word covers codes 16–31.
- R3: A strobe sampled at clock edge N gives vld_o high for exactly the cycle after edge N+1, with its verdict. Strobes on consecutive cycles give verdicts on consecutive cycles, in the same order.
- R4: vld_o stays low in any cycle that has no strobe two edges earlier.
- R5: A host write with no strobe in the same cycle is acknowledged in that cycle (wr_ack_o high). It is stored at the edge, and lookups strobed on any later edge see the new word.
- R6: When a host write and a strobe occur in the same cycle, wr_ack_o is low and the write is not performed.
- R7: A host write to a word address outside 0x300–0x3FF is acknowledged but changes no table word.
- R8: mode_o, valid with vld_o, is 1 when the looked-up subaddress was 0 or 31, and 0 otherwise.
- R9: While reset is asserted and after its release, vld_o, illegal_o and mode_o are low until a lookup completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req_i | input | 1 | Lookup strobe |
| lk_own_i | input | 1 | 1 = own address, 0 = broadcast |
| lk_tx_i | input | 1 | 1 = transmit, 0 = receive |
| lk_sa_i | input | 5 | Subaddress |
| lk_code_i | input | 5 | Word count or mode code |
| wr_en_i | input | 1 | Host write request |
| wr_addr_i | input | 10 | Host write word address |
| wr_data_i | input | 16 | Host write data |
| wr_ack_o | output | 1 | Host write accepted this cycle |
| vld_o | output | 1 | Verdict done pulse |
| illegal_o | output | 1 | 1 = command illegal |
| mode_o | output | 1 | Field was treated as a mode code |

## Verification
The table is filled with random words. A long stream of random lookups follows, with random idle gaps, so that every address field and every bit position is exercised, and the order of back-to-back verdicts is checked against strobes without gaps. Directed lookups at the four quadrant bases and at the two ends of a subaddress pair (codes 0, 15, 16 and 31) would catch a swapped own/tx bit or a swapped lower/upper word. Subaddresses 0, 31 and 1 separate the mode-code cases from the word-count case. Write-then-lookup, write-with-strobe collisions and writes to 0x045 and 0x245 show whether stored data really follows only accepted, in-range writes.

// File: rtl/cmd_illegal_lookup.sv
module cmd_illegal_lookup #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int TABLE_WORDS = 256,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req_i,
  input  logic              lk_own_i,
  input  logic              lk_tx_i,
  input  logic [4:0]        lk_sa_i,
  input  logic [4:0]        lk_code_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ack_o,
  output logic              vld_o,
  output logic              illegal_o,
  output logic              mode_o
);
  localparam int IDX_W = $clog2(TABLE_WORDS);
  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tbl [TABLE_WORDS];
  logic [DATA_W-1:0] rd_q;
  logic [BIT_W-1:0]  bit_q;
  logic              pend_q, mode_q;

  wire [IDX_W-1:0] rd_idx  = {lk_own_i, lk_tx_i, lk_sa_i, lk_code_i[4]};
  wire             in_tbl  = wr_addr_i[ADDR_W-1:IDX_W] == TABLE_BASE[ADDR_W-1:IDX_W];
  wire             is_mode = (lk_sa_i == 5'd0) || (lk_sa_i == 5'd31);

  assign wr_ack_o = wr_en_i && !lk_req_i;

  always_ff @(posedge clk) begin
    if (lk_req_i)
      rd_q <= tbl[rd_idx];
    else if (wr_en_i && in_tbl)
      tbl[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      bit_q     <= '0;
      mode_q    <= 1'b0;
      vld_o     <= 1'b0;
      illegal_o <= 1'b0;
      mode_o    <= 1'b0;
    end else begin
      pend_q <= lk_req_i;
      if (lk_req_i) begin
        bit_q  <= lk_code_i[BIT_W-1:0];
        mode_q <= is_mode;
      end
      vld_o     <= pend_q;
      illegal_o <= pend_q && rd_q[bit_q];
      mode_o    <= pend_q && mode_q;
    end
  end
endmodule

// File: rtl/cmd_illegal_lookup_chk.sv
module cmd_illegal_lookup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_req_i,
  input logic [4:0] lk_sa_i,
  input logic       wr_en_i,
  input logic       wr_ack_o,
  input logic       vld_o,
  input logic       illegal_o,
  input logic       mode_o
);
  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> ##1 vld_o);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req_i |=> ##1 !vld_o);
  assert_write_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !lk_req_i) |-> wr_ack_o);
  assert_lookup_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |-> !wr_ack_o);
  assert_mode_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> ##1 (mode_o == ($past(lk_sa_i, 2) == 5'd0 || $past(lk_sa_i, 2) == 5'd31)));
  assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (!illegal_o && !mode_o));
endmodule

bind cmd_illegal_lookup cmd_illegal_lookup_chk u_chk (.*);

// File: tb/cmd_illegal_lookup_tb.sv
module cmd_illegal_lookup_tb;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0, lk_own = 0, lk_tx = 0;
  logic [4:0] lk_sa = 0, lk_code = 0;
  logic wr_en = 0;
  logic [9:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic wr_ack, vld, illegal, mode;
  logic [15:0] model [256];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cmd_illegal_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req_i(lk_req), .lk_own_i(lk_own), .lk_tx_i(lk_tx),
    .lk_sa_i(lk_sa), .lk_code_i(lk_code), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_ack_o(wr_ack), .vld_o(vld), .illegal_o(illegal), .mode_o(mode));

  function automatic bit exp_ill(bit own, bit tx, logic [4:0] sa, logic [4:0] code);
    return model[{own, tx, sa, code[4]}][code[3:0]];
  endfunction

  function automatic bit exp_mode(logic [4:0] sa);
    return sa == 5'd0 || sa == 5'd31;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [9:0] a, logic [15:0] d, string req);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    #1 chk(req, wr_ack, 1);
    if (a[9:8] == 2'b11) model[a[7:0]] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(bit own, bit tx, logic [4:0] sa, logic [4:0] code, string req);
    @(negedge clk);
    lk_req = 1; lk_own = own; lk_tx = tx; lk_sa = sa; lk_code = code;
    @(negedge clk);
    lk_req = 0;
    chk("R3", vld, 0);
    @(negedge clk);
    chk("R3", vld, 1);
    chk(req, illegal, exp_ill(own, tx, sa, code));
    chk("R8", mode, exp_mode(sa));
    @(negedge clk);
    chk("R3", vld, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit pv0 = 0, pv1 = 0, pi0 = 0, pi1 = 0, pm0 = 0, pm1 = 0;
    void'($urandom(32'h1553));
    repeat (3) @(negedge clk);
    chk("R9", {vld, illegal, mode}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R9", {vld, illegal, mode}, 0);

    for (int i = 0; i < 256; i++) host_write(10'h300 + 10'(i), 16'($urandom), "R5");

    host_write(10'h3FF, 16'h8000, "R5");
    host_write(10'h3FE, 16'h0001, "R5");
    host_write(10'h300, 16'h0001, "R5");
    host_write(10'h340, 16'h8000, "R5");
    host_write(10'h380, 16'h0002, "R5");
    host_write(10'h3C0, 16'h0004, "R5");
    lookup(1, 1, 5'd31, 5'd31, "R2");
    lookup(1, 1, 5'd31, 5'd0, "R2");
    lookup(1, 1, 5'd31, 5'd16, "R2");
    lookup(1, 1, 5'd31, 5'd15, "R2");
    lookup(0, 0, 5'd0, 5'd0, "R1");
    lookup(0, 1, 5'd0, 5'd15, "R1");
    lookup(1, 0, 5'd0, 5'd1, "R1");
    lookup(1, 1, 5'd0, 5'd2, "R1");
    lookup(0, 0, 5'd1, 5'd3, "R8");

    for (int c = 0; c < 3000; c++) begin
      bit go;
      @(negedge clk);
      chk("R4", vld, pv1);
      if (pv1) begin
        chk("R3", illegal, pi1);
        chk("R8", mode, pm1);
      end
      pv1 = pv0; pi1 = pi0; pm1 = pm0;
      go = (c < 2996) && ($urandom % 4 != 0);
      lk_req = go; lk_own = 1'($urandom); lk_tx = 1'($urandom);
      lk_sa = 5'($urandom); lk_code = 5'($urandom);
      pv0 = go;
      pi0 = go && exp_ill(lk_own, lk_tx, lk_sa, lk_code);
      pm0 = go && exp_mode(lk_sa);
    end
    lk_req = 0;

    host_write(10'h345, 16'h0000, "R5");
    @(negedge clk);
    lk_req = 1; lk_own = 0; lk_tx = 1; lk_sa = 5'd2; lk_code = 5'd16;
    wr_en = 1; wr_addr = 10'h345; wr_data = 16'hFFFF;
    #1 chk("R6", wr_ack, 0);
    @(negedge clk);
    lk_req = 0; wr_en = 0;
    chk("R6", illegal, 0);
    @(negedge clk);
    chk("R6", vld, 1);
    chk("R6", illegal, 0);
    lookup(0, 1, 5'd2, 5'd16, "R6");
    lookup(0, 1, 5'd2, 5'd31, "R6");

    host_write(10'h245, 16'hFFFF, "R7");
    host_write(10'h045, 16'hFFFF, "R7");
    lookup(0, 1, 5'd2, 5'd16, "R7");
    lookup(0, 1, 5'd2, 5'd23, "R7");

    @(negedge clk);
    wr_en = 1; wr_addr = 10'h3A7; wr_data = 16'h0400;
    #1 chk("R5", wr_ack, 1);
    model[8'hA7] = 16'h0400;
    @(negedge clk);
    wr_en = 0;
    lk_req = 1; lk_own = 1; lk_tx = 0; lk_sa = 5'd19; lk_code = 5'd26;
    @(negedge clk);
    lk_req = 0;
    @(negedge clk);
    chk("R5", vld, 1);
    chk("R5", illegal, 1);
    lookup(1, 0, 5'd19, 5'd25, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule